// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block counts hardware events for software profiling. It holds a small bank of event counters, each programmed to follow one line of an event pulse vector or a software increment. It also holds one free-running cycle counter. A privilege-level input lets each counter ignore activity at user or at kernel level. Software reaches every register through a single-cycle write/read port. The read data is a combinational function of the address and of the current state.

A counter that wraps sets a sticky status bit. That status, combined with a per-bit interrupt enable, drives one level-sensitive interrupt line. The cycle counter can be slowed by a fixed prescaler of 64. Its overflow point can sit at bit 32 or at bit 64.

Registers are addressed by `reg_addr`:

| Address | Function |
|---|---|
| 0 | control |
| 1 | selector |
| 2 | type/filter of the selected counter |
| 3 | value of the selected counter |
| 4 | count-enable set (write 1 sets) |
| 5 | count-enable clear (write 1 clears) |
| 6 | overflow status (write 1 clears) |
| 7 | interrupt-enable set |
| 8 | interrupt-enable clear |
| 9 | software increment |

In every mask register, bit i stands for event counter i and bit 31 for the cycle counter. Reads of 4/5 and of 7/8 both return the mask; address 9 reads zero.

Top module: `perf_mon_bank`

## Requirements
- R1: Control bit 0 is a global run bit. While it is 0, no counter changes except by a register write or a control clear.
- R2: Writing control with bit 1 set zeroes every event counter in the next cycle, even if an event pulse arrives in the same cycle. The cycle counter keeps its value.
- R3: Writing control with bit 2 set zeroes the cycle counter and its prescaler remainder. The event counters keep their values.
- R4: With control bit 3 set, the cycle counter advances once per 64 enabled clock cycles. With bit 3 clear, it advances on every enabled cycle.
- R5: The cycle counter is 64 bits wide and always increments across bit 32. With control bit 6 clear it flags overflow when its low 32 bits wrap. With bit 6 set it flags overflow only when all 64 bits wrap.
- R6: A control read returns bits 0, 3 and 6 as written. It returns the number of event counters in bits 15:11. All other bits, including bits 1 and 2, read 0. After reset the control register reads only that count.
- R7: The selector takes wdata[4:0]. Addresses 2 and 3 reach the counter it names, and index 31 always names the cycle counter.
- R8: An event counter counts only when its count-enable bit and the run bit are set. Its type field wdata[9:0] picks the source: value n from 1 to the number of event lines picks `evt_i[n-1]`. Larger values never count.
- R9: Type bit 30 set stops counting while `priv_i` is 0 (user). Type bit 31 set stops counting while `priv_i` is 1 (kernel).
- R10: Type value 0 makes a counter advance only when software writes 1 to its bit at address 9. Event pulses do not advance it.
- R11: With the selector on an index that is neither implemented nor 31, addresses 2 and 3 read 0. Writes through them change no counter.
- R12: A counter wrap sets its overflow status bit. Writing 1 clears the bit, but a wrap in the same cycle as that clear leaves the bit set.
- R13: `irq_o` is high exactly while some overflow status bit is set together with its interrupt-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr |
| evt_i | input | NUM_EVT (8) | Single-cycle event pulses |
| priv_i | input | 1 | Current level: 0 user, 1 kernel |
| irq_o | output | 1 | Overflow interrupt, level |

## Verification
Three pairs of actions can fall in the same clock cycle and have a defined winner:

- A counter wrap and a software write-1-clear of that counter's overflow bit. The bench loads a counter with all ones, then drives the clear write and the event pulse in one cycle. It expects the status bit to remain set.
- An event-counter clear and an event pulse. The bench drives them together and expects zero rather than one.
- A control write that clears the cycle counter while the counter is still running. The bench expects the clear to win over the count.

// File: rtl/pmu_pkg.sv
// Package: shared register addresses, type-register layout and the
// privilege filter used by every counter of the performance monitor.
package pmu_pkg;

    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_SEL    = 4'd1;
    localparam logic [3:0] A_TYPE   = 4'd2;
    localparam logic [3:0] A_VALUE  = 4'd3;
    localparam logic [3:0] A_ENSET  = 4'd4;
    localparam logic [3:0] A_ENCLR  = 4'd5;
    localparam logic [3:0] A_OVF    = 4'd6;
    localparam logic [3:0] A_IESET  = 4'd7;
    localparam logic [3:0] A_IECLR  = 4'd8;
    localparam logic [3:0] A_SWINC  = 4'd9;

    localparam logic [4:0] CYC_IDX  = 5'd31;
    localparam int         PRESCALE = 64;

    typedef struct packed {
        logic       skip_kernel;   // bit 31 of the type register
        logic       skip_user;     // bit 30 of the type register
        logic [9:0] evt_num;       // bits 9:0 of the type register
    } ctr_cfg_t;

    // True when counting is allowed at the current privilege level.
    function automatic logic level_ok(input ctr_cfg_t cfg, input logic kernel);
        return kernel ? !cfg.skip_kernel : !cfg.skip_user;
    endfunction

endpackage

// File: rtl/pmu_event_ctr.sv
// Module: one programmable event counter.
// Picks its source from the event vector (number n selects line n-1) or,
// for number 0, from the software-increment strobe; gates it by the run
// condition and the privilege filter. Assumes clear and load never need
// to coexist with counting: both take precedence over an increment.
module pmu_event_ctr
    import pmu_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               kernel,
    input  ctr_cfg_t           cfg,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               sw_inc,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    input  logic               clear,
    output logic [CNT_W-1:0]   value,
    output logic               wrap
);

    logic hit;
    logic inc;

    // Source selection: software strobe for number 0, else matching line.
    always_comb begin
        hit = 1'b0;
        if (cfg.evt_num == 10'd0) begin
            hit = sw_inc;
        end else begin
            for (int k = 0; k < NUM_EVT; k++) begin
                if (cfg.evt_num == 10'(k + 1)) hit = evt[k];
            end
        end
    end

    assign inc  = run && hit && level_ok(cfg, kernel);
    assign wrap = inc && !clear && !load && (&value);

    // Counter state: clear, then load, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      value <= '0;
        else if (clear)  value <= '0;
        else if (load)   value <= load_val;
        else if (inc)    value <= value + 1'b1;
    end

    // R1
    ev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load && !clear) |=> $stable(value));

    // R12
    ev_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (value == '0));

endmodule

// File: rtl/pmu_cycle_ctr.sv
// Module: the 64-bit cycle counter with optional divide-by-PRESCALE.
// Counts enabled clock cycles; in divided mode a remainder counter
// carries partial progress. Overflow is flagged at the 32-bit or the
// 64-bit point. Assumes PRESCALE is a power of two of at least 2.
module pmu_cycle_ctr
    import pmu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        pass,
    input  logic        div_en,
    input  logic        long_mode,
    input  logic        load,
    input  logic [63:0] load_val,
    input  logic        clear,
    output logic [63:0] value,
    output logic        wrap
);

    localparam int REM_W = $clog2(PRESCALE);
    localparam logic [REM_W-1:0] REM_LAST = REM_W'(PRESCALE - 1);

    logic [REM_W-1:0] rem;
    logic             tick;
    logic             step;

    assign tick = run && pass;
    assign step = tick && (!div_en || rem == REM_LAST);
    assign wrap = step && !clear && !load &&
                  (long_mode ? (&value) : (&value[31:0]));

    // Prescaler remainder: advances on every enabled cycle in divided mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rem <= '0;
        else if (clear)             rem <= '0;
        else if (tick && div_en)    rem <= rem + 1'b1;
    end

    // Counter state: clear, then load, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)      value <= '0;
        else if (clear)  value <= '0;
        else if (load)   value <= load_val;
        else if (step)   value <= value + 64'd1;
    end

    // R4
    cyc_prescale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_en && rem != REM_LAST && !load && !clear) |=> $stable(value));

    // R3
    cyc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (value == 64'd0 && rem == '0));

endmodule

// File: rtl/perf_mon_bank.sv
// Module: performance monitor top. Holds the control, selector, type,
// enable, overflow and interrupt-enable registers, decodes the register
// port, instantiates NUM_CTR event counters and the cycle counter, and
// drives the level interrupt. Assumes 1 <= NUM_CTR <= 30.
module perf_mon_bank
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int NUM_EVT = 8,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [3:0]         reg_addr,
    input  logic [63:0]        reg_wdata,
    output logic [63:0]        reg_rdata,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               priv_i,
    output logic               irq_o
);

    localparam logic [4:0]  NCTR_F = 5'(NUM_CTR);
    localparam logic [31:0] VALID  = {1'b1, {(31 - NUM_CTR){1'b0}}, {NUM_CTR{1'b1}}};

    logic        run_q, div_q, long_q;
    logic [4:0]  sel_q;
    ctr_cfg_t    cfg_q [NUM_CTR];
    ctr_cfg_t    cyc_cfg_q;
    logic [31:0] en_q, ie_q, ovf_q;

    logic [CNT_W-1:0]   ev_val  [NUM_CTR];
    logic [NUM_CTR-1:0] ev_wrap;
    logic [63:0]        cyc_val;
    logic               cyc_wrap;
    logic [31:0]        wrap_v;

    logic     wr_ctrl, wr_type, wr_value, wr_ovf, wr_swinc;
    logic     sel_cyc;
    ctr_cfg_t wcfg;

    assign wr_ctrl  = reg_we && reg_addr == A_CTRL;
    assign wr_type  = reg_we && reg_addr == A_TYPE;
    assign wr_value = reg_we && reg_addr == A_VALUE;
    assign wr_ovf   = reg_we && reg_addr == A_OVF;
    assign wr_swinc = reg_we && reg_addr == A_SWINC;
    assign sel_cyc  = sel_q == CYC_IDX;
    assign wcfg     = '{skip_kernel: reg_wdata[31], skip_user: reg_wdata[30],
                        evt_num: reg_wdata[9:0]};

    // Control and selector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            div_q  <= 1'b0;
            long_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q  <= reg_wdata[0];
                div_q  <= reg_wdata[3];
                long_q <= reg_wdata[6];
            end
            if (reg_we && reg_addr == A_SEL) sel_q <= reg_wdata[4:0];
        end
    end

    // Mask registers: count enable, interrupt enable, sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            ie_q  <= '0;
            ovf_q <= '0;
        end else begin
            if (reg_we && reg_addr == A_ENSET) en_q <= (en_q | reg_wdata[31:0]) & VALID;
            if (reg_we && reg_addr == A_ENCLR) en_q <= en_q & ~reg_wdata[31:0];
            if (reg_we && reg_addr == A_IESET) ie_q <= (ie_q | reg_wdata[31:0]) & VALID;
            if (reg_we && reg_addr == A_IECLR) ie_q <= ie_q & ~reg_wdata[31:0];
            ovf_q <= ((wr_ovf ? (ovf_q & ~reg_wdata[31:0]) : ovf_q) | wrap_v) & VALID;
        end
    end

    // Cycle counter filter register (index 31 type access).
    always_ff @(posedge clk) begin
        if (!rst_n)                  cyc_cfg_q <= '0;
        else if (wr_type && sel_cyc) cyc_cfg_q <= '{skip_kernel: wcfg.skip_kernel,
                                                    skip_user: wcfg.skip_user,
                                                    evt_num: 10'd0};
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CTR; gi++) begin : g_ev
            logic hit_sel;
            assign hit_sel = sel_q == 5'(gi);

            // Type register of this event counter.
            always_ff @(posedge clk) begin
                if (!rst_n)                  cfg_q[gi] <= '0;
                else if (wr_type && hit_sel) cfg_q[gi] <= wcfg;
            end

            pmu_event_ctr #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) i_ctr (
                .clk      (clk),
                .rst_n    (rst_n),
                .run      (run_q && en_q[gi]),
                .kernel   (priv_i),
                .cfg      (cfg_q[gi]),
                .evt      (evt_i),
                .sw_inc   (wr_swinc && reg_wdata[gi]),
                .load     (wr_value && hit_sel),
                .load_val (reg_wdata[CNT_W-1:0]),
                .clear    (wr_ctrl && reg_wdata[1]),
                .value    (ev_val[gi]),
                .wrap     (ev_wrap[gi])
            );
        end
    endgenerate

    pmu_cycle_ctr i_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q && en_q[31]),
        .pass      (level_ok(cyc_cfg_q, priv_i)),
        .div_en    (div_q),
        .long_mode (long_q),
        .load      (wr_value && sel_cyc),
        .load_val  (reg_wdata),
        .clear     (wr_ctrl && reg_wdata[2]),
        .value     (cyc_val),
        .wrap      (cyc_wrap)
    );

    // Gather wrap pulses into the mask layout.
    always_comb begin
        wrap_v              = '0;
        wrap_v[NUM_CTR-1:0] = ev_wrap;
        wrap_v[31]          = cyc_wrap;
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {48'd0, NCTR_F, 4'd0, long_q, 2'd0, div_q, 2'd0, run_q};
            A_SEL:   reg_rdata = {59'd0, sel_q};
            A_TYPE: begin
                if (sel_cyc) reg_rdata = {32'd0, cyc_cfg_q.skip_kernel, cyc_cfg_q.skip_user, 30'd0};
                for (int k = 0; k < NUM_CTR; k++) begin
                    if (sel_q == 5'(k))
                        reg_rdata = {32'd0, cfg_q[k].skip_kernel, cfg_q[k].skip_user,
                                     20'd0, cfg_q[k].evt_num};
                end
            end
            A_VALUE: begin
                if (sel_cyc) reg_rdata = cyc_val;
                for (int k = 0; k < NUM_CTR; k++) begin
                    if (sel_q == 5'(k)) reg_rdata = 64'(ev_val[k]);
                end
            end
            A_ENSET, A_ENCLR: reg_rdata = {32'd0, en_q};
            A_IESET, A_IECLR: reg_rdata = {32'd0, ie_q};
            A_OVF:            reg_rdata = {32'd0, ovf_q};
            default:          reg_rdata = '0;
        endcase
    end

    assign irq_o = |(ovf_q & ie_q);

    // R12
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ovf |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

    // R13
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ovf && reg_wdata[31:0] == 32'hFFFF_FFFF && wrap_v == '0) |=> !irq_o);

endmodule

// File: tb/test_perf_mon_bank.sv
module test_perf_mon_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NEV = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [63:0] reg_wdata;
    logic [63:0] reg_rdata;
    logic [NEV-1:0] evt_i;
    logic        priv_i;
    logic        irq_o;
    int n_chk = 0;
    int n_err = 0;
    logic [63:0] v;

    perf_mon_bank #(.NUM_CTR(4), .NUM_EVT(NEV), .CNT_W(32)) i_perf_mon_bank (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
        .priv_i(priv_i), .irq_o(irq_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [63:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [NEV-1:0] m);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        evt_i = '0; priv_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6 reset state
        rd(0, v); check("R6 reset ctrl", v, 64'(4 << 11));
        rd(6, v); check("R12 reset ovf", v, 0);
        check("R13 reset irq", 64'(irq_o), 0);

        wr(4, 64'hF);
        wr(0, 64'h1);
        // R8 R7 sweep: every counter, every event number, every line
        for (int i = 0; i < 4; i++) begin
            wr(1, 64'(i));
            for (int e = 0; e < NEV; e++) begin
                wr(2, 64'(e + 1));
                wr(3, 64'd0);
                for (int j = 0; j < NEV; j++) begin
                    pulse(NEV'(1 << j));
                    rd(3, v);
                    check($sformatf("R8 ctr%0d evt%0d line%0d", i, e, j), v, (j >= e) ? 1 : 0);
                end
            end
        end
        // R8 out-of-range number never counts
        wr(2, 64'(NEV + 1)); wr(3, 0); pulse('1);
        rd(3, v); check("R8 out of range", v, 0);
        // R8 count enable clear
        wr(1, 0); wr(2, 1); wr(3, 0); wr(5, 64'h1); pulse(1);
        rd(3, v); check("R8 enable cleared", v, 0);
        wr(4, 64'h1);
        // R1 global run bit
        wr(0, 0); pulse(1);
        rd(3, v); check("R1 run off", v, 0);
        wr(0, 1); pulse(1);
        rd(3, v); check("R1 run on", v, 1);

        // R9 filter sweep
        for (int p = 0; p < 2; p++) begin
            for (int ex = 0; ex < 4; ex++) begin
                wr(2, (64'(ex) << 30) | 64'd1); wr(3, 0);
                priv_i = p[0];
                pulse(1);
                rd(3, v);
                check($sformatf("R9 priv%0d excl%0d", p, ex), v,
                      ((p == 0 && ex[0]) || (p == 1 && ex[1])) ? 0 : 1);
            end
        end
        priv_i = 1'b0;
        wr(2, 1);

        // R10 software increment
        wr(1, 1); wr(2, 0); wr(3, 0);
        wr(9, 64'h2); rd(3, v); check("R10 swinc", v, 1);
        pulse('1);    rd(3, v); check("R10 pulse ignored", v, 1);
        wr(9, 64'h1); rd(3, v); check("R10 other bit", v, 1);

        // R11 unimplemented index
        for (int i = 0; i < 4; i++) begin wr(1, 64'(i)); wr(2, 1); wr(3, 64'(100 + i)); end
        wr(1, 5); wr(3, 64'd123); wr(2, 64'd3);
        rd(3, v); check("R11 value reads 0", v, 0);
        rd(2, v); check("R11 type reads 0", v, 0);
        for (int i = 0; i < 4; i++) begin
            wr(1, 64'(i)); rd(3, v);
            check($sformatf("R11 ctr%0d untouched", i), v, 64'(100 + i));
        end

        // R2 event clear wins over a same-cycle pulse; cycle counter kept
        wr(1, 31); wr(3, 64'd77);
        reg_we = 1'b1; reg_addr = 0; reg_wdata = 64'h3; evt_i = 1;
        @(negedge clk);
        reg_we = 1'b0; evt_i = 0;
        for (int i = 0; i < 4; i++) begin
            wr(1, 64'(i)); rd(3, v); check($sformatf("R2 ctr%0d cleared", i), v, 0);
        end
        wr(1, 31); rd(3, v); check("R2 cycle kept", v, 77);

        // R3 R4 prescaled cycle counting
        wr(1, 0); wr(3, 5); wr(1, 31);
        wr(4, 64'h8000_0000);
        wr(0, 64'hD);
        repeat (62) @(negedge clk);
        wr(0, 64'h8);
        rd(3, v); check("R4 63 ticks", v, 0);
        wr(0, 64'h9); wr(0, 64'h8);
        rd(3, v); check("R4 64 ticks", v, 1);
        wr(0, 64'h4);
        rd(3, v); check("R3 cycle cleared", v, 0);
        wr(1, 0); rd(3, v); check("R3 event kept", v, 5);
        wr(1, 31);
        wr(0, 1); repeat (9) @(negedge clk); wr(0, 0);
        rd(3, v); check("R4 undivided", v, 10);

        // R5 overflow point
        wr(3, 64'hFFFF_FFFF); wr(6, 64'hFFFF_FFFF);
        wr(0, 1); wr(0, 0);
        rd(3, v); check("R5 short value", v, 64'h1_0000_0000);
        rd(6, v); check("R5 short ovf", v, 64'h8000_0000);
        wr(6, 64'hFFFF_FFFF);
        wr(3, 64'hFFFF_FFFF); wr(0, 64'h41); wr(0, 64'h40);
        rd(3, v); check("R5 long value", v, 64'h1_0000_0000);
        rd(6, v); check("R5 long no ovf", v, 0);
        wr(3, '1); wr(0, 64'h41); wr(0, 64'h40);
        rd(3, v); check("R5 long wrap", v, 0);
        rd(6, v); check("R5 long ovf", v, 64'h8000_0000);
        wr(6, 64'hFFFF_FFFF);

        // R6 readback
        wr(5, 64'h8000_0000);
        wr(0, 64'h4F); rd(0, v); check("R6 readback", v, 64'h49 | 64'(4 << 11));
        rd(1, v); check("R7 selector", v, 31);

        // R12 R13 overflow and interrupt
        wr(0, 1); wr(1, 0); wr(2, 1); wr(3, 64'hFFFF_FFFF);
        pulse(1);
        rd(3, v); check("R12 wrapped", v, 0);
        rd(6, v); check("R12 status set", v, 1);
        check("R13 masked", 64'(irq_o), 0);
        wr(7, 64'h1); check("R13 raised", 64'(irq_o), 1);
        wr(3, 64'hFFFF_FFFF);
        reg_we = 1'b1; reg_addr = 6; reg_wdata = 64'h1; evt_i = 1;
        @(negedge clk);
        reg_we = 1'b0; evt_i = 0;
        rd(6, v); check("R12 set beats clear", v, 1);
        wr(6, 64'h1);
        rd(6, v); check("R12 w1c", v, 0);
        check("R13 dropped", 64'(irq_o), 0);
        wr(1, 1); wr(2, 2); wr(3, 64'hFFFF_FFFF); pulse(2);
        rd(6, v); check("R12 ctr1 status", v, 2);
        check("R13 other bit masked", 64'(irq_o), 0);

        finish_run();
    end
endmodule